// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves an integer-divider PLL from one set of divider values to another without glitching the clocks that depend on it. A single start command carries the target pre-divider (NR), feedback multiplier (NF) and output divider (NO). It also carries a flag saying the target rate is simply the reference rate, and the value the bypass control bit should take. The sequencer then walks a fixed series of one-cycle register writes and timed waits. It drives four 16-bit control words of the analog PLL and a 2-bit mode selector. The selector encodes 0 = slow (reference passes straight through), 1 = normal (PLL output) and 2 = deep slow.

The control words are updated through a write bus whose upper half-word is a bit mask, so each step changes only its own field. After the dividers are loaded and reset is released, a settle delay that depends on NR runs first. The sequencer then polls the lock input for a bounded number of cycles. If lock never arrives, the dividers that were in place before the command are reprogrammed through the same sequence, and this rollback happens once. A combinational readback output reports the output rate implied by the current register contents.

States and transitions: IDLE goes to BYPASS on start. BYPASS goes to REF_SLOW when the target is the reference rate, to PWR_UP when the readback equalled the reference at start, and to SLOW otherwise. REF_SLOW goes to PWR_DOWN, then to DONE. PWR_UP goes to SLOW. The chain then runs SLOW, RST_ON, WR_W0, WR_W1, WR_W2, RST_OFF and SETTLE, ending in LOCK. LOCK goes to NORMAL on lock. On expiry it goes to SLOW for the single rollback, or to NORMAL if the rollback was already used. NORMAL goes to DONE, and DONE returns to IDLE.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `mode_sel` is 0 (slow), all four control words are 0, `busy`, `done`, `timeout_flag` and `restore_tried` are 0, and `rate_out` equals `ref_rate`.
- R2: `rate_out` equals `ref_rate` when word 3 bit 0 (bypass) is set or `mode_sel` is not 1. Otherwise it equals ref_rate*(NFf+1)/((NRf+1)*(NOf+1)) truncated to 32 bits, where NRf, NOf and NFf are the stored fields. `mode_sel` changes only while `busy` is high.
- R3: After a normal reprogram, word 0 holds NO-1 in bits 3:0 and NR-1 in bits 13:8. Word 1 holds NF-1 in bits 12:0, and word 2 holds NF>>1 in bits 11:0. Word 3 bit 5 (reset) is 0 and `mode_sel` is 1. Reset bit 5 is never high while idle.
- R4: A command with `cmd_to_ref`=1 ends with `mode_sel`=0 and word 3 bit 1 (power-down) set, and leaves words 0 to 2 unchanged.
- R5: If `rate_out` equals `ref_rate` when a non-reference command is accepted, power-down is cleared before reprogramming, so word 3 bit 1 is 0 at the end.
- R6: With lock high, `mode_sel` becomes 1 exactly ((NR*500)/24+1)*CLK_PER_US + 2 cycles after word 3 bit 5 falls.
- R7: If lock stays low for LOCK_TIMEOUT cycles, `timeout_flag` and `restore_tried` are set and the previous words 0 to 2 are reprogrammed. The sequence then ends with `mode_sel`=1.
- R8: A second timeout during the rollback ends the sequence with `done`, `timeout_flag`=1, `mode_sel`=1 and the previous dividers in place.
- R9: A start seen while `busy` is high is ignored. `busy` is high from the cycle after an accepted start through the `done` cycle, and `done` is a one-cycle pulse.
- R10: The command's bypass value is written to word 3 bit 0.
- R11: Each write changes only the bits selected by its mask. The bypass bit survives the later power-down and reset writes to word 3.
- R12: Accepting a start clears `timeout_flag` and `restore_tried` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | command strobe |
| cmd_nr | input | 7 | target NR (1..64) |
| cmd_nf | input | 14 | target NF (1..8192) |
| cmd_no | input | 5 | target NO (1..16) |
| cmd_to_ref | input | 1 | target equals the reference rate |
| cmd_bypass | input | 1 | value for the bypass bit |
| lock_in | input | 1 | PLL lock status |
| ref_rate | input | 32 | reference rate for readback |
| ctl_w0 | output | 16 | control word 0 (NR, NO) |
| ctl_w1 | output | 16 | control word 1 (NF) |
| ctl_w2 | output | 16 | control word 2 (bandwidth) |
| ctl_w3 | output | 16 | control word 3 (bypass, power-down, reset) |
| mode_sel | output | 2 | mode selector |
| busy | output | 1 | sequence in progress |
| done | output | 1 | end-of-sequence pulse |
| timeout_flag | output | 1 | lock timeout seen |
| restore_tried | output | 1 | rollback performed |
| rate_out | output | 32 | computed output rate |

## Verification
The bench times the settle window from the falling reset bit to normal mode for several NR values. An off-by-one counter, or a delay that ignores NR or CLK_PER_US, shows up as a wrong cycle count. It forces lock timeouts twice: once with lock rising during rollback, which catches a design that restores the wrong dividers or skips rollback, and once with lock never rising, which catches a design that loops forever or leaves slow mode. It also pushes a start into a busy sequence, where a design that accepts it would end with the wrong dividers. It follows a reference-rate command with a normal one, where a design that forgets to clear power-down leaves bit 1 set. A bypassed command exposes unmasked writes that wipe the bypass bit.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int NR_W   = 6;
    localparam int NO_W   = 4;
    localparam int NF_W   = 13;
    localparam int BW_W   = 12;
    localparam int WORD_W = 16;
    localparam int NWORDS = 4;

    localparam logic [1:0] MODE_SLOW   = 2'd0;
    localparam logic [1:0] MODE_NORMAL = 2'd1;
    localparam logic [1:0] MODE_DEEP   = 2'd2;

    localparam int BIT_BYP = 0;
    localparam int BIT_PD  = 1;
    localparam int BIT_RST = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_BYPASS, ST_REF_SLOW, ST_PWR_DOWN, ST_PWR_UP, ST_SLOW,
        ST_RST_ON, ST_WR_W0, ST_WR_W1, ST_WR_W2, ST_RST_OFF, ST_SETTLE,
        ST_LOCK, ST_NORMAL, ST_DONE
    } seq_state_t;

    function automatic logic [2*WORD_W-1:0] mk_wr(input logic [WORD_W-1:0] msk,
                                                  input logic [WORD_W-1:0] dat);
        return {msk, dat};
    endfunction
endpackage

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_seq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [1:0]                    wr_idx_i,
    input  logic [2*WORD_W-1:0]           wr_bus_i,
    output logic [NWORDS-1:0][WORD_W-1:0] words_o
);
    logic [NWORDS-1:0][WORD_W-1:0] words_q;
    logic [WORD_W-1:0] msk, dat;

    assign msk = wr_bus_i[2*WORD_W-1:WORD_W];
    assign dat = wr_bus_i[WORD_W-1:0];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == 2'(g)))
                words_q[g] <= (words_q[g] & ~msk) | (dat & msk);
        end
    end

    assign words_o = words_q;

    // R11
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (((words_q[$past(wr_idx_i)] ^ $past(words_q[wr_idx_i]))
                      & ~$past(wr_bus_i[2*WORD_W-1:WORD_W])) == '0));
endmodule

// File: rtl/pll_wait_cnt.sv
module pll_wait_cnt #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_seq_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] ref_i,
    input  logic [NR_W-1:0]   nr_f_i,
    input  logic [NO_W-1:0]   no_f_i,
    input  logic [NF_W-1:0]   nf_f_i,
    input  logic              bypass_i,
    input  logic [1:0]        mode_i,
    output logic [RATE_W-1:0] rate_o
);
    localparam int PW = RATE_W + NF_W + 1;
    localparam int DW = NR_W + NO_W + 2;

    logic [NF_W:0]   nf_v;
    logic [NR_W:0]   nr_v;
    logic [NO_W:0]   no_v;
    logic [DW-1:0]   dv;
    logic [PW-1:0]   prod, quo;

    always_comb begin
        nf_v = {1'b0, nf_f_i} + 1'b1;
        nr_v = {1'b0, nr_f_i} + 1'b1;
        no_v = {1'b0, no_f_i} + 1'b1;
        dv   = DW'(nr_v) * DW'(no_v);
        prod = PW'(ref_i) * PW'(nf_v);
        quo  = prod / PW'(dv);
        if (bypass_i || (mode_i != MODE_NORMAL))
            rate_o = ref_i;
        else
            rate_o = quo[RATE_W-1:0];
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_PER_US   = 24,
    parameter int LOCK_TIMEOUT = 24000000,
    parameter int RATE_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NR_W:0]     cmd_nr,
    input  logic [NF_W:0]     cmd_nf,
    input  logic [NO_W:0]     cmd_no,
    input  logic              cmd_to_ref,
    input  logic              cmd_bypass,
    input  logic              lock_in,
    input  logic [RATE_W-1:0] ref_rate,
    output logic [WORD_W-1:0] ctl_w0,
    output logic [WORD_W-1:0] ctl_w1,
    output logic [WORD_W-1:0] ctl_w2,
    output logic [WORD_W-1:0] ctl_w3,
    output logic [1:0]        mode_sel,
    output logic              busy,
    output logic              done,
    output logic              timeout_flag,
    output logic              restore_tried,
    output logic [RATE_W-1:0] rate_out
);
    localparam int SETTLE_MAX = ((((1 << NR_W) * 500) / 24) + 1) * CLK_PER_US;
    localparam int CNT_MAX    = (SETTLE_MAX > LOCK_TIMEOUT) ? SETTLE_MAX : LOCK_TIMEOUT;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    seq_state_t state_q, state_d;

    logic [NR_W-1:0] wk_nr_q, old_nr_q;
    logic [NO_W-1:0] wk_no_q, old_no_q;
    logic [NF_W-1:0] wk_nf_q, old_nf_q;
    logic            to_ref_q, at_ref_q, byp_q;
    logic [1:0]      mode_q;

    logic                          wr_en;
    logic [1:0]                    wr_idx;
    logic [2*WORD_W-1:0]           wr_bus;
    logic                          mode_wr;
    logic [1:0]                    mode_val;
    logic [NWORDS-1:0][WORD_W-1:0] words;

    logic             cnt_load, cnt_last;
    logic [CNT_W-1:0] cnt_val;
    logic [31:0]      settle_us, settle_cyc;
    logic [NF_W:0]    nf_full;
    logic             lock_expire;

    assign lock_expire = (state_q == ST_LOCK) && !lock_in && cnt_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_BYPASS;
            ST_BYPASS:   state_d = to_ref_q ? ST_REF_SLOW : (at_ref_q ? ST_PWR_UP : ST_SLOW);
            ST_REF_SLOW: state_d = ST_PWR_DOWN;
            ST_PWR_DOWN: state_d = ST_DONE;
            ST_PWR_UP:   state_d = ST_SLOW;
            ST_SLOW:     state_d = ST_RST_ON;
            ST_RST_ON:   state_d = ST_WR_W0;
            ST_WR_W0:    state_d = ST_WR_W1;
            ST_WR_W1:    state_d = ST_WR_W2;
            ST_WR_W2:    state_d = ST_RST_OFF;
            ST_RST_OFF:  state_d = ST_SETTLE;
            ST_SETTLE:   if (cnt_last) state_d = ST_LOCK;
            ST_LOCK: begin
                if (lock_in)          state_d = ST_NORMAL;
                else if (cnt_last)    state_d = restore_tried ? ST_NORMAL : ST_SLOW;
            end
            ST_NORMAL:   state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        nf_full    = {1'b0, wk_nf_q} + 1'b1;
        settle_us  = ((32'(wk_nr_q) + 32'd1) * 32'd500) / 32'd24 + 32'd1;
        settle_cyc = settle_us * 32'(CLK_PER_US);
        wr_en    = 1'b0;
        wr_idx   = 2'd0;
        wr_bus   = '0;
        mode_wr  = 1'b0;
        mode_val = MODE_SLOW;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_BYPASS: begin
                wr_en = 1'b1; wr_idx = 2'd3;
                wr_bus = mk_wr(16'(1) << BIT_BYP, 16'(byp_q) << BIT_BYP);
            end
            ST_REF_SLOW, ST_SLOW: begin
                mode_wr = 1'b1; mode_val = MODE_SLOW;
            end
            ST_PWR_DOWN: begin
                wr_en = 1'b1; wr_idx = 2'd3;
                wr_bus = mk_wr(16'(1) << BIT_PD, 16'(1) << BIT_PD);
            end
            ST_PWR_UP: begin
                wr_en = 1'b1; wr_idx = 2'd3;
                wr_bus = mk_wr(16'(1) << BIT_PD, 16'd0);
            end
            ST_RST_ON: begin
                wr_en = 1'b1; wr_idx = 2'd3;
                wr_bus = mk_wr(16'(1) << BIT_RST, 16'(1) << BIT_RST);
            end
            ST_WR_W0: begin
                wr_en = 1'b1; wr_idx = 2'd0;
                wr_bus = mk_wr(16'h3F0F, {2'b00, wk_nr_q, 4'b0000, wk_no_q});
            end
            ST_WR_W1: begin
                wr_en = 1'b1; wr_idx = 2'd1;
                wr_bus = mk_wr(16'h1FFF, {3'b000, wk_nf_q});
            end
            ST_WR_W2: begin
                wr_en = 1'b1; wr_idx = 2'd2;
                wr_bus = mk_wr(16'h0FFF, {4'b0000, nf_full[BW_W:1]});
            end
            ST_RST_OFF: begin
                wr_en = 1'b1; wr_idx = 2'd3;
                wr_bus = mk_wr(16'(1) << BIT_RST, 16'd0);
                cnt_load = 1'b1; cnt_val = CNT_W'(settle_cyc);
            end
            ST_SETTLE: begin
                cnt_load = cnt_last; cnt_val = CNT_W'(LOCK_TIMEOUT);
            end
            ST_NORMAL: begin
                mode_wr = 1'b1; mode_val = MODE_NORMAL;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_nr_q <= '0; wk_no_q <= '0; wk_nf_q <= '0;
            old_nr_q <= '0; old_no_q <= '0; old_nf_q <= '0;
            to_ref_q <= 1'b0; at_ref_q <= 1'b0; byp_q <= 1'b0;
            timeout_flag <= 1'b0; restore_tried <= 1'b0;
            mode_q <= MODE_SLOW;
        end else begin
            if (mode_wr)
                mode_q <= mode_val;
            if ((state_q == ST_IDLE) && start) begin
                wk_nr_q  <= NR_W'(cmd_nr - 1'b1);
                wk_no_q  <= NO_W'(cmd_no - 1'b1);
                wk_nf_q  <= NF_W'(cmd_nf - 1'b1);
                old_nr_q <= words[0][13:8];
                old_no_q <= words[0][3:0];
                old_nf_q <= words[1][NF_W-1:0];
                to_ref_q <= cmd_to_ref;
                at_ref_q <= (rate_out == ref_rate);
                byp_q    <= cmd_bypass;
                timeout_flag  <= 1'b0;
                restore_tried <= 1'b0;
            end
            if (lock_expire) begin
                timeout_flag <= 1'b1;
                if (!restore_tried) begin
                    restore_tried <= 1'b1;
                    wk_nr_q <= old_nr_q;
                    wk_no_q <= old_no_q;
                    wk_nf_q <= old_nf_q;
                end
            end
        end
    end

    pll_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_bus_i(wr_bus), .words_o(words)
    );

    pll_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(cnt_val),
        .last_o(cnt_last)
    );

    pll_rate_calc #(.RATE_W(RATE_W)) u_rate (
        .ref_i(ref_rate), .nr_f_i(words[0][13:8]), .no_f_i(words[0][3:0]),
        .nf_f_i(words[1][NF_W-1:0]), .bypass_i(words[3][BIT_BYP]),
        .mode_i(mode_q), .rate_o(rate_out)
    );

    assign ctl_w0   = words[0];
    assign ctl_w1   = words[1];
    assign ctl_w2   = words[2];
    assign ctl_w3   = words[3];
    assign mode_sel = mode_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(mode_sel));
    // R7
    restore_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_tried |-> timeout_flag);
    // R8
    timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_flag) |-> (mode_sel == MODE_NORMAL));
    // R3
    idle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ctl_w3[BIT_RST]);
endmodule

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
    localparam int CPU = 2;
    localparam int LTO = 40;
    localparam logic [31:0] REF = 32'd24000000;
    localparam logic [31:0] VEC [4] = '{
        {8'd1, 16'd50,  8'd2},
        {8'd2, 16'd100, 8'd4},
        {8'd3, 16'd75,  8'd1},
        {8'd1, 16'd64,  8'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [6:0] cmd_nr = 7'd1;
    logic [13:0] cmd_nf = 14'd1;
    logic [4:0] cmd_no = 5'd1;
    logic cmd_to_ref = 1'b0, cmd_bypass = 1'b0, lock_in = 1'b1;
    logic [15:0] w0, w1, w2, w3;
    logic [1:0] mode_sel;
    logic busy, done, timeout_flag, restore_tried;
    logic [31:0] rate_out;

    int errors = 0, checks = 0;
    int settle_cnt = -1, meas = 0, run_cnt = 0;
    logic prev_rst = 1'b0;
    logic [15:0] prior0, prior1;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(.CLK_PER_US(CPU), .LOCK_TIMEOUT(LTO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_nr(cmd_nr), .cmd_nf(cmd_nf),
        .cmd_no(cmd_no), .cmd_to_ref(cmd_to_ref), .cmd_bypass(cmd_bypass),
        .lock_in(lock_in), .ref_rate(REF), .ctl_w0(w0), .ctl_w1(w1), .ctl_w2(w2),
        .ctl_w3(w3), .mode_sel(mode_sel), .busy(busy), .done(done),
        .timeout_flag(timeout_flag), .restore_tried(restore_tried), .rate_out(rate_out)
    );

    always @(negedge clk) begin
        if (meas != 0) begin
            run_cnt = run_cnt + 1;
            if (mode_sel == 2'd1) begin settle_cnt = run_cnt; meas = 0; end
        end else if (prev_rst && !w3[5]) begin
            run_cnt = 0; meas = 1;
        end
        prev_rst = w3[5];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int nr, input int nf, input int no, input bit to_ref, input bit byp);
        @(negedge clk);
        cmd_nr = 7'(nr); cmd_nf = 14'(nf); cmd_no = 5'(no);
        cmd_to_ref = to_ref; cmd_bypass = byp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, "R9 done reached", longint'(done), 1);
        @(negedge clk);
        chk(!done && !busy, "R9 done pulse", longint'({done, busy}), 0);
    endtask

    function automatic longint exp_rate(input int nr, input int nf, input int no);
        return (longint'(REF) * nf / (nr * no)) & 64'hFFFF_FFFF;
    endfunction

    function automatic int exp_settle(input int nr);
        return ((nr * 500) / 24 + 1) * CPU + 2;
    endfunction

    initial begin
        #750000;
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_sel == 2'd0 && w0 == 0 && w1 == 0 && w2 == 0 && w3 == 0, "R1 regs", longint'(w3), 0);
        chk(!busy && !done && !timeout_flag && !restore_tried, "R1 flags", longint'(busy), 0);
        chk(rate_out == REF, "R1 rate", longint'(rate_out), longint'(REF));

        for (int i = 0; i < 4; i++) begin
            int nr = int'(VEC[i][31:24]), nf = int'(VEC[i][23:8]), no = int'(VEC[i][7:0]);
            settle_cnt = -1;
            issue(nr, nf, no, 1'b0, 1'b0);
            wait_done();
            chk(w0 == 16'(((nr - 1) << 8) | (no - 1)), "R3 word0", longint'(w0), ((nr - 1) << 8) | (no - 1));
            chk(w1 == 16'(nf - 1), "R3 word1", longint'(w1), nf - 1);
            chk(w2 == 16'(nf >> 1), "R3 word2", longint'(w2), nf >> 1);
            chk(mode_sel == 2'd1 && !w3[5], "R3 mode/reset", longint'(mode_sel), 1);
            chk(rate_out == 32'(exp_rate(nr, nf, no)), "R2 rate", longint'(rate_out), exp_rate(nr, nf, no));
            chk(settle_cnt == exp_settle(nr), "R6 settle", settle_cnt, exp_settle(nr));
        end

        prior0 = w0; prior1 = w1;
        issue(5, 5, 5, 1'b1, 1'b0);
        wait_done();
        chk(mode_sel == 2'd0 && w3[1], "R4 slow+pd", longint'({mode_sel, w3[1]}), 1);
        chk(w0 == prior0 && w1 == prior1, "R4 dividers kept", longint'(w0), longint'(prior0));
        chk(rate_out == REF, "R2 slow rate", longint'(rate_out), longint'(REF));

        issue(1, 50, 2, 1'b0, 1'b0);
        wait_done();
        chk(!w3[1], "R5 pd cleared", longint'(w3[1]), 0);
        chk(mode_sel == 2'd1, "R5 mode", longint'(mode_sel), 1);

        issue(2, 100, 4, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(busy, "R9 busy", longint'(busy), 1);
        issue(3, 75, 1, 1'b0, 1'b0);
        wait_done();
        chk(w0 == 16'h0103 && w1 == 16'd99, "R9 start ignored", longint'(w0), 16'h0103);

        issue(3, 75, 1, 1'b0, 1'b1);
        wait_done();
        chk(w3[0] == 1'b1, "R10 bypass bit", longint'(w3[0]), 1);
        chk(w3[0] && !w3[5] && w0 == 16'h0200, "R11 masked keep", longint'(w3), 1);
        chk(rate_out == REF, "R2 bypass rate", longint'(rate_out), longint'(REF));
        issue(1, 64, 8, 1'b0, 1'b0);
        wait_done();
        chk(!w3[0] && rate_out == 32'(exp_rate(1, 64, 8)), "R10 bypass cleared", longint'(rate_out), exp_rate(1, 64, 8));

        prior0 = w0; prior1 = w1;
        lock_in = 1'b0;
        fork
            begin
                while (!restore_tried) @(negedge clk);
                lock_in = 1'b1;
            end
        join_none
        issue(2, 100, 4, 1'b0, 1'b0);
        wait_done();
        chk(timeout_flag && restore_tried, "R7 flags", longint'({timeout_flag, restore_tried}), 3);
        chk(w0 == prior0 && w1 == prior1, "R7 rollback dividers", longint'(w0), longint'(prior0));
        chk(mode_sel == 2'd1, "R7 mode", longint'(mode_sel), 1);

        prior0 = w0; prior1 = w1;
        lock_in = 1'b0;
        issue(3, 75, 1, 1'b0, 1'b0);
        wait_done();
        chk(timeout_flag && restore_tried && mode_sel == 2'd1, "R8 double timeout", longint'({timeout_flag, mode_sel}), 5);
        chk(w0 == prior0 && w1 == prior1, "R8 dividers", longint'(w0), longint'(prior0));

        lock_in = 1'b1;
        issue(1, 50, 2, 1'b0, 1'b0);
        chk(!timeout_flag && !restore_tried, "R12 flags cleared", longint'({timeout_flag, restore_tried}), 0);
        wait_done();
        chk(!timeout_flag && mode_sel == 2'd1, "R12 clean run", longint'(timeout_flag), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule